// File: doc/BRIEF.md
# Small Multi-Mode 8-bit Processor Core

This block is an 8-bit processor core with an accumulator-free register file: four general registers, a base register and two scratch registers. Three ALU operations (addition, bitwise AND, bitwise OR) take their second operand in one of three ways: straight from a register, from memory at the address held in a register, or from memory at the base register plus an unsigned displacement byte. A fourth operation loads the base register from an immediate byte. The result of every ALU operation goes back to the destination register.

A multicycle sequencer steps each instruction through fetch, decode, optional extra byte fetch, optional operand read, execute and writeback. Inside the datapath, sources are put onto two internal buses at the falling clock edge, and destinations capture from those buses at the rising edge. Outside the core there is an 8-bit address bus and a bidirectional 8-bit data bus, both released (high impedance) when the core is not in a bus cycle, plus read and write strobes to a byte-addressable memory that answers a read in the same cycle.

Top module: `mini_cisc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, all four general registers and the base register to zero. While reset is held, `memRd` and `memWr` stay low. The first read after reset fetches address 0x00.
- R2: An opcode byte is decoded as follows. Bits [7:6] select the operation: 00 add, 01 AND, 10 OR, 11 load-base. Bits [5:4] select the operand mode: 00 register, 01 register-indirect, 10 base-plus-displacement, 11 reserved. Bits [3:2] give the destination register and bits [1:0] give the source or pointer register.
- R3: Addition is two's-complement modulo 256, and the sum is written to the destination register.
- R4: AND and OR are bitwise, and the result is written to the destination register.
- R5: A register-mode instruction is one byte long and takes 5 cycles. It performs no memory access other than its fetch.
- R6: A register-indirect instruction is one byte long and takes 7 cycles. Its single operand read uses the pointer register's value as the address.
- R7: A base-plus-displacement instruction is two bytes long and takes 11 cycles. The second byte is an unsigned displacement. The operand address is (base + displacement) mod 256.
- R8: Load-base is two bytes long and takes 6 cycles. The second byte is loaded into the base register. Bits [5:0] of its opcode are ignored, and no general register changes.
- R9: An add, AND or OR opcode with reserved mode 11 is one byte long and takes 3 cycles. It changes no register.
- R10: The program counter advances by one for every instruction or displacement byte fetched, and it wraps from 0xFF to 0x00.
- R11: Every read cycle lasts exactly one clock with `memRd` high. The address bus is driven only in a bus cycle. No instruction asserts `memWr` or drives the data bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; sequencer and captures on the rising edge, bus driving on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 8 | Memory address, high impedance outside bus cycles |
| memData | inout | 8 | Memory data, sampled at the end of a read cycle |
| memRd | output | 1 | Read strobe, one cycle per memory read |
| memWr | output | 1 | Write strobe |

## Verification
Two things happen at the same rising edge in every byte fetch: the address-out register captures the program counter from internal bus A, and the program counter increments. The capture must see the old value while the counter moves on. This is provoked by chains of back-to-back instructions of every length, by two-byte instructions whose displacement fetch repeats the pattern mid-instruction, and by a run of 260 one-byte instructions that carries the counter through the 0xFF to 0x00 wrap. It is judged from the sequence of read addresses and the cycle spacing observed at the ports. Those are compared against an instruction-level model, which also exposes register contents: pointer-register reads put the register value on the address bus.

// File: rtl/cisc_pkg.sv
package cisc_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = DATA_W;
  localparam int NUM_REGS  = 4;
  localparam int REG_SEL_W = $clog2(NUM_REGS);

  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_AND = 2'b01, OP_OR = 2'b10, OP_LBI = 2'b11} opKind_e;
  typedef enum logic [1:0] {M_REG = 2'b00, M_IND = 2'b01, M_BASE = 2'b10, M_RSV = 2'b11} addrMode_e;

  typedef enum logic [3:0] {
    S_FETCH_ADR, S_FETCH_RD, S_DECODE, S_DISP_ADR, S_DISP_RD, S_DISP_MOV,
    S_EA_CALC, S_OPND_ADR, S_OPND_RD, S_EXEC, S_WRITE, S_LOAD_BASE
  } seqState_e;

  typedef enum logic [2:0] {A_IDLE, A_PC, A_RDST, A_RSRC, A_BASE, A_T1} busASrc_e;
  typedef enum logic [1:0] {B_IDLE, B_RSRC, B_DIN, B_T2} busBSrc_e;

  typedef struct packed {
    busASrc_e               aSrc;
    busBSrc_e               bSrc;
    logic                   ldAo;
    logic                   incPc;
    logic                   memRd;
    logic                   memWr;
    logic                   ldDi;
    logic                   ldDo;
    logic                   ldT1;
    logic                   ldT2;
    logic                   ldBase;
    logic                   ldDst;
    logic                   forceAdd;
    opKind_e                aluOp;
    logic [REG_SEL_W-1:0]   dstSel;
    logic [REG_SEL_W-1:0]   srcSel;
  } ctlBus_t;
endpackage

// File: rtl/cisc_alu.sv
module cisc_alu
  import cisc_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  opKind_e           op,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_ADD:  res = opA + opB;
      OP_AND:  res = opA & opB;
      OP_OR:   res = opA | opB;
      default: res = opB;
    endcase
  end
endmodule

// File: rtl/cisc_ctrl.sv
module cisc_ctrl
  import cisc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memIn,
  output ctlBus_t           ctl
);
  seqState_e        state, nextState;
  logic [DATA_W-1:0] instr;
  opKind_e          op;
  addrMode_e        mode;

  assign op   = opKind_e'(instr[7:6]);
  assign mode = addrMode_e'(instr[5:4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH_ADR;
      instr <= '0;
    end else begin
      state <= nextState;
      if (state == S_FETCH_RD) instr <= memIn;
    end
  end

  always_comb begin
    nextState = S_FETCH_ADR;
    unique case (state)
      S_FETCH_ADR: nextState = S_FETCH_RD;
      S_FETCH_RD:  nextState = S_DECODE;
      S_DECODE: begin
        if (op == OP_LBI) nextState = S_DISP_ADR;
        else begin
          unique case (mode)
            M_REG:   nextState = S_EXEC;
            M_IND:   nextState = S_OPND_ADR;
            M_BASE:  nextState = S_DISP_ADR;
            default: nextState = S_FETCH_ADR;
          endcase
        end
      end
      S_DISP_ADR:  nextState = S_DISP_RD;
      S_DISP_RD:   nextState = (op == OP_LBI) ? S_LOAD_BASE : S_DISP_MOV;
      S_DISP_MOV:  nextState = S_EA_CALC;
      S_EA_CALC:   nextState = S_OPND_ADR;
      S_OPND_ADR:  nextState = S_OPND_RD;
      S_OPND_RD:   nextState = S_EXEC;
      S_EXEC:      nextState = S_WRITE;
      S_WRITE:     nextState = S_FETCH_ADR;
      S_LOAD_BASE: nextState = S_FETCH_ADR;
      default:     nextState = S_FETCH_ADR;
    endcase
  end

  always_comb begin
    ctl          = '0;
    ctl.aSrc     = A_IDLE;
    ctl.bSrc     = B_IDLE;
    ctl.aluOp    = op;
    ctl.dstSel   = instr[3:2];
    ctl.srcSel   = instr[1:0];
    unique case (state)
      S_FETCH_ADR, S_DISP_ADR: begin
        ctl.aSrc  = A_PC;
        ctl.ldAo  = 1'b1;
        ctl.incPc = 1'b1;
      end
      S_FETCH_RD: ctl.memRd = 1'b1;
      S_DISP_RD, S_OPND_RD: begin
        ctl.memRd = 1'b1;
        ctl.ldDi  = 1'b1;
      end
      S_DISP_MOV: begin
        ctl.bSrc = B_DIN;
        ctl.ldT2 = 1'b1;
      end
      S_EA_CALC: begin
        ctl.aSrc     = A_BASE;
        ctl.bSrc     = B_T2;
        ctl.ldT1     = 1'b1;
        ctl.forceAdd = 1'b1;
      end
      S_OPND_ADR: begin
        ctl.aSrc = (mode == M_BASE) ? A_T1 : A_RSRC;
        ctl.ldAo = 1'b1;
      end
      S_EXEC: begin
        ctl.aSrc = A_RDST;
        ctl.bSrc = (mode == M_REG) ? B_RSRC : B_DIN;
        ctl.ldT1 = 1'b1;
      end
      S_WRITE: begin
        ctl.aSrc  = A_T1;
        ctl.ldDst = 1'b1;
      end
      S_LOAD_BASE: begin
        ctl.bSrc   = B_DIN;
        ctl.ldBase = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cisc_datapath.sv
module cisc_datapath
  import cisc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctlBus_t           ctl,
  input  logic [DATA_W-1:0] memIn,
  output logic [ADDR_W-1:0] aoVal,
  output logic [DATA_W-1:0] doVal
);
  logic [DATA_W-1:0] gpr [NUM_REGS];
  logic [DATA_W-1:0] pc, baseReg, t1, t2, dinReg, doReg;
  logic [ADDR_W-1:0] aoReg;
  logic [DATA_W-1:0] busA, busB, aluOut;

  // Register-to-bus transfers: falling edge
  always_ff @(negedge clk) begin
    if (rst) begin
      busA <= '0;
      busB <= '0;
    end else begin
      unique case (ctl.aSrc)
        A_PC:    busA <= pc;
        A_RDST:  busA <= gpr[ctl.dstSel];
        A_RSRC:  busA <= gpr[ctl.srcSel];
        A_BASE:  busA <= baseReg;
        A_T1:    busA <= t1;
        default: busA <= busA;
      endcase
      unique case (ctl.bSrc)
        B_RSRC:  busB <= gpr[ctl.srcSel];
        B_DIN:   busB <= dinReg;
        B_T2:    busB <= t2;
        default: busB <= busB;
      endcase
    end
  end

  cisc_alu uAlu (
    .opA (busA),
    .opB (busB),
    .op  (ctl.forceAdd ? OP_ADD : ctl.aluOp),
    .res (aluOut)
  );

  // Bus-to-register transfers: rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      baseReg <= '0;
      t1      <= '0;
      t2      <= '0;
      dinReg  <= '0;
      doReg   <= '0;
      aoReg   <= '0;
    end else begin
      if (ctl.incPc)  pc      <= pc + 1'b1;
      if (ctl.ldAo)   aoReg   <= busA;
      if (ctl.ldDi)   dinReg  <= memIn;
      if (ctl.ldDo)   doReg   <= busB;
      if (ctl.ldT1)   t1      <= aluOut;
      if (ctl.ldT2)   t2      <= busB;
      if (ctl.ldBase) baseReg <= busB;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk) begin
      if (rst) gpr[g] <= '0;
      else if (ctl.ldDst && (ctl.dstSel == REG_SEL_W'(g))) gpr[g] <= busA;
    end
  end

  assign aoVal = aoReg;
  assign doVal = doReg;
endmodule

// File: rtl/mini_cisc_core.sv
module mini_cisc_core
  import cisc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memRd,
  output logic              memWr
);
  ctlBus_t           ctl;
  logic [ADDR_W-1:0] aoVal;
  logic [DATA_W-1:0] doVal;

  cisc_ctrl uCtrl (
    .clk   (clk),
    .rst   (rst),
    .memIn (memData),
    .ctl   (ctl)
  );

  cisc_datapath uDp (
    .clk   (clk),
    .rst   (rst),
    .ctl   (ctl),
    .memIn (memData),
    .aoVal (aoVal),
    .doVal (doVal)
  );

  assign memAddr = (ctl.memRd || ctl.memWr) ? aoVal : 'z;
  assign memData = ctl.memWr ? doVal : 'z;
  assign memRd   = ctl.memRd;
  assign memWr   = ctl.memWr;
endmodule

// File: rtl/cisc_checker.sv
module cisc_checker
  import cisc_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    memRd,
  input logic    memWr,
  input ctlBus_t ctl
);
  // R11: a read strobe never lasts longer than one cycle
  a_r11_read_single: assert property (@(posedge clk) disable iff (rst)
    memRd |=> !memRd);

  // R11: reads and writes never overlap
  a_r11_read_not_write: assert property (@(posedge clk) disable iff (rst)
    memRd |-> !memWr);

  // R10: each counter step is followed by the read of that byte
  a_r10_step_then_read: assert property (@(posedge clk) disable iff (rst)
    ctl.incPc |=> memRd);

  // R2: at most one capture target per decoded step
  a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.ldT1, ctl.ldT2, ctl.ldBase, ctl.ldDst, ctl.ldAo, ctl.ldDi}));

  // R7: staged displacement is followed by the forced address sum
  a_r7_disp_then_sum: assert property (@(posedge clk) disable iff (rst)
    ctl.ldT2 |=> (ctl.forceAdd && ctl.ldT1));

  // R1: the first cycle out of reset starts a fetch, without a read
  a_r1_fetch_first: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!memRd && ctl.incPc));
endmodule

bind mini_cisc_core cisc_checker uChk (
  .clk   (clk),
  .rst   (rst),
  .memRd (memRd),
  .memWr (memWr),
  .ctl   (ctl)
);

// File: tb/tb_mini_cisc_core.sv
`timescale 1ns/1ps
module tb_mini_cisc_core;
  localparam int MAXEV = 600;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] memAddr;
  wire  [7:0] memData;
  logic       memRd, memWr;
  logic [7:0] mem [256];

  int checks = 0, errors = 0, cyc = 0;
  int nRec = 0, wrSeen = 0, nExp = 0, progLen = 0;
  int recAddr [MAXEV];
  int recCyc  [MAXEV];
  int expAddr [MAXEV];
  int expCyc  [MAXEV];

  always #5 clk = ~clk;

  mini_cisc_core dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memData(memData), .memRd(memRd), .memWr(memWr)
  );

  assign memData = memRd ? mem[memAddr] : 'z;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!rst && memRd && nRec < MAXEV) begin
      recAddr[nRec] = int'(memAddr);
      recCyc[nRec]  = cyc;
      nRec++;
    end
    if (!rst && memWr) wrSeen++;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not finish, act hung exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act 0x%0h exp 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ins(input int op, input int mode, input int d, input int s);
    return {op[1:0], mode[1:0], d[1:0], s[1:0]};
  endfunction

  task automatic clear_mem(input logic [7:0] fill);
    for (int i = 0; i < 256; i++) mem[i] = fill;
    progLen = 0;
  endtask

  task automatic put(input logic [7:0] b);
    mem[progLen] = b;
    progLen++;
  endtask

  task automatic push(input int a, input int t);
    if (nExp < MAXEV) begin
      expAddr[nExp] = a;
      expCyc[nExp]  = t;
      nExp++;
    end
  endtask

  // Instruction-level model built from the requirements
  task automatic build_model(input int endPc, input int maxEv);
    logic [7:0] pc, b, opc, arg, ea, v;
    logic [7:0] r [4];
    int t, op, md, d, s;
    pc = 0; b = 0; t = 0; nExp = 0;
    for (int i = 0; i < 4; i++) r[i] = 0;
    while (nExp < maxEv && int'(pc) != endPc) begin
      opc = mem[pc]; push(int'(pc), t + 1); pc++;
      op = int'(opc[7:6]); md = int'(opc[5:4]); d = int'(opc[3:2]); s = int'(opc[1:0]);
      if (op == 3) begin
        arg = mem[pc]; push(int'(pc), t + 4); pc++;
        b = arg; t += 6;
      end else begin
        v = 0;
        if (md == 0) begin v = r[s]; t += 5; end
        else if (md == 1) begin ea = r[s]; push(int'(ea), t + 4); v = mem[ea]; t += 7; end
        else if (md == 2) begin
          arg = mem[pc]; push(int'(pc), t + 4); pc++;
          ea = b + arg; push(int'(ea), t + 8); v = mem[ea]; t += 11;
        end else t += 3;
        if (md != 3) begin
          if (op == 0) r[d] = r[d] + v;
          else if (op == 1) r[d] = r[d] & v;
          else r[d] = r[d] | v;
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); nRec = 0; wrSeen = 0;
    @(negedge clk);
    chk(memRd == 1'b0, "R1", "memRd during reset", int'(memRd), 0);
    chk(memWr == 1'b0, "R1", "memWr during reset", int'(memWr), 0);
    rst = 1'b0;
  endtask

  task automatic run_prog(input string tag, input int endPc, input int maxEv);
    int guard = 0;
    build_model(endPc, maxEv);
    do_reset();
    while (nRec < nExp && guard < 5000) begin @(negedge clk); guard++; end
    chk(nRec >= nExp, tag, "read count", nRec, nExp);
    for (int i = 0; i < nExp && i < nRec; i++) begin
      chk(recAddr[i] == expAddr[i], tag, $sformatf("read %0d address", i), recAddr[i], expAddr[i]);
      chk(recCyc[i] - recCyc[0] == expCyc[i] - expCyc[0], tag, $sformatf("read %0d cycle", i),
          recCyc[i] - recCyc[0], expCyc[i] - expCyc[0]);
    end
    chk(wrSeen == 0, "R11", "write strobes seen", wrSeen, 0);
  endtask

  task automatic probe_all();
    for (int x = 0; x < 4; x++) put(ins(2, 1, 3 - x, x));
    put(ins(0, 2, 0, 0)); put(8'h00);
  endtask

  task automatic t_reset();      // R1: state cleared by reset
    clear_mem(8'h00);
    probe_all();
    run_prog("R1", progLen, MAXEV);
    chk(recAddr[0] == 0, "R1", "first fetch address", recAddr[0], 0);
  endtask

  task automatic t_add();        // R3, R5
    clear_mem(8'h00);
    mem[8'h80] = 8'h7F; mem[8'h81] = 8'h85; mem[8'h82] = 8'hFE; mem[8'h83] = 8'h03;
    put(ins(3, 0, 0, 0)); put(8'h80);
    for (int x = 0; x < 4; x++) begin put(ins(0, 2, x, 0)); put(8'(x)); end
    put(ins(0, 0, 0, 1)); put(ins(0, 0, 2, 3)); put(ins(0, 0, 1, 1));
    probe_all();
    run_prog("R3/R5", progLen, MAXEV);
  endtask

  task automatic t_logic();      // R4, R5
    clear_mem(8'h00);
    mem[8'h90] = 8'hF0; mem[8'h91] = 8'h3C;
    put(ins(3, 0, 0, 0)); put(8'h90);
    put(ins(0, 2, 0, 0)); put(8'h00);
    put(ins(0, 2, 1, 0)); put(8'h01);
    put(ins(1, 0, 0, 1)); put(ins(2, 0, 2, 1)); put(ins(1, 0, 3, 3)); put(ins(2, 0, 1, 1));
    probe_all();
    run_prog("R4/R5", progLen, MAXEV);
  endtask

  task automatic t_indirect();   // R6
    clear_mem(8'h00);
    mem[8'hA0] = 8'hC0; mem[8'hC0] = 8'h55; mem[8'h55] = 8'h0F;
    put(ins(3, 0, 0, 0)); put(8'hA0);
    put(ins(0, 2, 0, 0)); put(8'h00);
    put(ins(0, 1, 1, 0)); put(ins(2, 1, 2, 1)); put(ins(1, 1, 1, 0));
    probe_all();
    run_prog("R6", progLen, MAXEV);
  endtask

  task automatic t_base();       // R7: unsigned displacement, wrapped sum
    clear_mem(8'h00);
    mem[8'h10] = 8'h77; mem[8'hEF] = 8'h12; mem[8'h80] = 8'h21;
    put(ins(3, 0, 0, 0)); put(8'hF0);
    put(ins(0, 2, 0, 0)); put(8'h20);
    put(ins(0, 2, 1, 0)); put(8'hFF);
    put(ins(3, 0, 0, 0)); put(8'h00);
    put(ins(2, 2, 2, 0)); put(8'h80);
    probe_all();
    run_prog("R7", progLen, MAXEV);
    chk(expAddr[4] == 8'h10 && recAddr[4] == 8'h10, "R7", "wrapped operand address", recAddr[4], 8'h10);
  endtask

  task automatic t_lbi();        // R8: low opcode bits ignored
    clear_mem(8'h00);
    mem[8'h44] = 8'h09; mem[8'h03] = 8'h30;
    put(8'hFF); put(8'h44);
    put(ins(0, 2, 0, 0)); put(8'h00);
    put(8'hC5); put(8'h01);
    put(ins(0, 2, 1, 1)); put(8'h02);
    probe_all();
    run_prog("R8", progLen, MAXEV);
  endtask

  task automatic t_reserved();   // R9
    clear_mem(8'h00);
    mem[8'hB0] = 8'h3A;
    put(ins(3, 0, 0, 0)); put(8'hB0);
    put(ins(0, 2, 0, 0)); put(8'h00);
    put(ins(0, 3, 0, 0)); put(ins(1, 3, 0, 0)); put(ins(2, 3, 0, 0));
    probe_all();
    run_prog("R9", progLen, MAXEV);
  endtask

  task automatic t_wrap();       // R10: counter wrap over a run of reserved no-ops
    clear_mem(ins(0, 3, 0, 0));
    run_prog("R10", 256, 260);
    chk(recAddr[256] == 0, "R10", "fetch after 0xFF", recAddr[256], 0);
    chk(recCyc[256] - recCyc[255] == 3, "R10", "spacing across wrap", recCyc[256] - recCyc[255], 3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_reset();
    t_logic();
    t_indirect();
    t_base();
    t_lbi();
    t_reserved();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule